// File: doc/BRIEF.md
# Addressed-Read Byte Sequencer for a Two-Wire Slave

This block handles the byte-level transactions of a two-wire slave. A separate bit-level front end finds the bus conditions and turns them into one-cycle event pulses. The events are START (including a repeated START), STOP, one pulse per data bit, a complete received byte, and the master's acknowledge or not-acknowledge after each byte the slave sent. From these events the sequencer decides whether the slave acknowledges, which byte it transmits next, and where its read pointer stands. A small register array covering addresses 80h to CFh sits inside the block. The sequencer reads this array and commits writes into it.

A random read works as a dummy write. The master sends the device address with the direction bit clear, then an address byte, then a repeated START, then the device address with the direction bit set. The slave then streams bytes starting at that address and advances the pointer after every byte it hands out. A write commits only when all of these hold:
- the write-enable input is high;
- the active-low protect input is high;
- the address lies in the window;
- exactly one data byte of exactly eight bits arrived;
- a STOP followed on a byte boundary.

Top module: `rand_read_seq`

## Requirements
- R1: After reset, `ack_valid` and `tx_load` are low, `rd_ptr` is 80h and every array byte reads 00h.
- R2: A received device address byte has upper nibble 1010b, bits 3:1 equal to `DEV_SEL` and bit 0 as the direction (1 = read). In the next cycle the block pulses `ack_valid`. `ack_out` is 1 when the byte matches and 0 when it does not. After a mismatch, further bytes get no `ack_valid` until the next START.
- R3: An address byte that follows an acknowledged write-direction device address is acknowledged and appears on `rd_ptr` one cycle after its `ev_byte`.
- R4: An acknowledged read-direction device address causes a `tx_load` pulse one cycle later. In that cycle `tx_byte` holds the byte at the previous pointer value, and `rd_ptr` has advanced by one (modulo 256).
- R5: A master acknowledge during a read loads the next byte and advances the pointer one cycle later. After a master not-acknowledge, no `tx_load` occurs until the next START.
- R6: A read from an address below 80h or above CFh returns FFh.
- R7: A write commits its data byte to the addressed location when a STOP arrives on a byte boundary after exactly one data byte, with `wel`=1 and `wp_n`=1.
- R8: With `wel`=0 or `wp_n`=0, the write does not change the array.
- R9: A STOP that arrives after one or more bit pulses of an unfinished byte abandons the pending write.
- R10: A byte whose `ev_byte` is not preceded by exactly eight `ev_bit` pulses is not acknowledged (`ack_out`=0). The sequencer then ignores bytes until START.
- R11: A second data byte in one write is not acknowledged and cancels the write.
- R12: When STOP and START occur in the same cycle, the pending write is committed and the following byte is decoded as a device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | START or repeated START seen |
| ev_stop | input | 1 | STOP seen |
| ev_bit | input | 1 | One data bit clocked on the bus |
| ev_byte | input | 1 | Received byte complete |
| rx_byte | input | 8 | Received byte, valid with `ev_byte` |
| ev_mack | input | 1 | Master acknowledge slot after a sent byte |
| mack_ack | input | 1 | 1 = master acknowledged, 0 = not-acknowledge |
| wel | input | 1 | Write-enable latch state |
| wp_n | input | 1 | Write protect, active low |
| ack_valid | output | 1 | Slave acknowledge decision is valid |
| ack_out | output | 1 | 1 = slave acknowledges the byte |
| tx_load | output | 1 | New byte ready on `tx_byte` |
| tx_byte | output | 8 | Byte to shift out |
| rd_ptr | output | 8 | Current read/write pointer |

## Verification
Two functions can coincide in one cycle: the commit of a pending write on STOP, and the start of a new transaction on START. The bench drives both pulses in the same cycle right after a valid data byte. It then sends a read-direction device address without a new address byte. The judgement is that the address is acknowledged and that the first byte sent is the newly written value, fetched from the pointer the write left in place. Random reads and writes under random protect and enable settings are compared against a byte model kept in the bench.

// File: rtl/rrs_pkg.sv
// Shared types and helpers for the addressed-read sequencer.
// Assumes addresses are AW-bit unsigned values.
package rrs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,   // waiting for START
        S_DEV,    // expecting device address byte
        S_WADR,   // expecting address byte
        S_WDAT,   // expecting the single data byte
        S_WEND,   // data held, waiting for STOP
        S_RDAT,   // transmitting bytes
        S_HOLD    // ignoring bytes until START or STOP
    } seq_state_t;

    localparam logic [3:0] DEV_FAMILY = 4'b1010;

    // true when addr lies inside [lo, hi]
    function automatic logic in_window(input logic [7:0] addr,
                                       input logic [7:0] lo,
                                       input logic [7:0] hi);
        return (addr >= lo) && (addr <= hi);
    endfunction

endpackage

// File: rtl/rrs_bitcount.sv
// Counts bit pulses since the last byte-level boundary.
// Assumes clear and inc never need to apply in the same cycle; clear wins.
module rrs_bitcount #(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic full,
    output logic zero
);
    localparam int CW = $clog2(BITS + 1) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] cnt;

    // saturating bit counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (inc && cnt != CMAX)
            cnt <= cnt + 1'b1;
    end

    assign full = (cnt == CW'(BITS));
    assign zero = (cnt == '0);
endmodule

// File: rtl/rrs_regs.sv
// Byte array covering addresses LO..HI with one read and one write port.
// Reads outside the window return all ones; writes outside are dropped.
module rrs_regs #(
    parameter int          AW = 8,
    parameter logic [AW-1:0] LO = 8'h80,
    parameter logic [AW-1:0] HI = 8'hCF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data
);
    localparam int DEPTH = int'(HI) - int'(LO) + 1;
    localparam int IW    = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    function automatic logic [IW-1:0] to_idx(input logic [AW-1:0] a);
        return IW'(a - LO);
    endfunction

    // asynchronous read with out-of-window fill
    always_comb begin
        if (rd_addr >= LO && rd_addr <= HI)
            rd_data = mem[to_idx(rd_addr)];
        else
            rd_data = 8'hFF;
    end

    // storage with reset to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en && wr_addr >= LO && wr_addr <= HI) begin
            mem[to_idx(wr_addr)] <= wr_data;
        end
    end
endmodule

// File: rtl/rrs_ctrl.sv
// Transaction state machine: decodes device and address bytes, drives
// the acknowledge decision, loads transmit bytes, holds the pointer and
// qualifies the single pending write. Assumes one event per cycle except
// that STOP and START may coincide.
module rrs_ctrl
    import rrs_pkg::*;
#(
    parameter logic [2:0] DEV_SEL = 3'b000,
    parameter logic [7:0] LO      = 8'h80,
    parameter logic [7:0] HI      = 8'hCF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       ev_byte,
    input  logic [7:0] rx_byte,
    input  logic       ev_mack,
    input  logic       mack_ack,
    input  logic       cnt_full,
    input  logic       cnt_zero,
    input  logic       wel,
    input  logic       wp_n,
    input  logic [7:0] rd_data,
    output logic       ack_valid,
    output logic       ack_out,
    output logic       tx_load,
    output logic [7:0] tx_byte,
    output logic [7:0] ptr,
    output logic       wr_go,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    seq_state_t state;
    logic [7:0] pend;
    logic       dev_hit;

    // device address match on family and select bits
    assign dev_hit = (rx_byte[7:4] == DEV_FAMILY) && (rx_byte[3:1] == DEV_SEL);

    // write qualification: held byte, byte boundary, enable, protect, window
    always_comb begin
        wr_go   = ev_stop && (state == S_WEND) && cnt_zero && wel && wp_n
                  && in_window(ptr, LO, HI);
        wr_addr = ptr;
        wr_data = pend;
    end

    // sequencing, acknowledge and transmit loading
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            ptr       <= LO;
            pend      <= 8'h00;
            ack_valid <= 1'b0;
            ack_out   <= 1'b0;
            tx_load   <= 1'b0;
            tx_byte   <= 8'h00;
        end else begin
            ack_valid <= 1'b0;
            tx_load   <= 1'b0;
            if (ev_start) begin
                state <= S_DEV;
            end else if (ev_stop) begin
                state <= S_IDLE;
            end else if (ev_byte) begin
                case (state)
                    S_DEV: begin
                        ack_valid <= 1'b1;
                        if (!cnt_full || !dev_hit) begin
                            ack_out <= 1'b0;
                            state   <= S_HOLD;
                        end else if (rx_byte[0]) begin
                            ack_out <= 1'b1;
                            tx_load <= 1'b1;
                            tx_byte <= rd_data;
                            ptr     <= ptr + 8'd1;
                            state   <= S_RDAT;
                        end else begin
                            ack_out <= 1'b1;
                            state   <= S_WADR;
                        end
                    end
                    S_WADR, S_WDAT: begin
                        ack_valid <= 1'b1;
                        if (!cnt_full) begin
                            ack_out <= 1'b0;
                            state   <= S_HOLD;
                        end else if (state == S_WADR) begin
                            ack_out <= 1'b1;
                            ptr     <= rx_byte;
                            state   <= S_WDAT;
                        end else begin
                            ack_out <= 1'b1;
                            pend    <= rx_byte;
                            state   <= S_WEND;
                        end
                    end
                    S_WEND: begin
                        ack_valid <= 1'b1;
                        ack_out   <= 1'b0;
                        state     <= S_HOLD;
                    end
                    default: ;
                endcase
            end else if (ev_mack && state == S_RDAT) begin
                if (mack_ack) begin
                    tx_load <= 1'b1;
                    tx_byte <= rd_data;
                    ptr     <= ptr + 8'd1;
                end else begin
                    state <= S_HOLD;
                end
            end
        end
    end
endmodule

// File: rtl/rand_read_seq.sv
// Top of the addressed-read sequencer: bit counter, controller and
// register array. Assumes event inputs are single-cycle pulses from a
// bit-level front end in the same clock domain.
module rand_read_seq #(
    parameter logic [2:0] DEV_SEL = 3'b000,
    parameter int         BITS    = 8,
    parameter logic [7:0] LO      = 8'h80,
    parameter logic [7:0] HI      = 8'hCF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       ev_bit,
    input  logic       ev_byte,
    input  logic [7:0] rx_byte,
    input  logic       ev_mack,
    input  logic       mack_ack,
    input  logic       wel,
    input  logic       wp_n,
    output logic       ack_valid,
    output logic       ack_out,
    output logic       tx_load,
    output logic [7:0] tx_byte,
    output logic [7:0] rd_ptr
);
    logic       cnt_full, cnt_zero, cnt_clr;
    logic [7:0] rd_data, wr_addr, wr_data;
    logic       wr_go;

    assign cnt_clr = ev_start | ev_stop | ev_byte | ev_mack;

    rrs_bitcount #(.BITS(BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clr), .inc(ev_bit),
        .full(cnt_full), .zero(cnt_zero)
    );

    rrs_ctrl #(.DEV_SEL(DEV_SEL), .LO(LO), .HI(HI)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .rx_byte(rx_byte), .ev_mack(ev_mack),
        .mack_ack(mack_ack), .cnt_full(cnt_full), .cnt_zero(cnt_zero),
        .wel(wel), .wp_n(wp_n), .rd_data(rd_data), .ack_valid(ack_valid),
        .ack_out(ack_out), .tx_load(tx_load), .tx_byte(tx_byte),
        .ptr(rd_ptr), .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    rrs_regs #(.AW(8), .LO(LO), .HI(HI)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_ptr), .rd_data(rd_data),
        .wr_en(wr_go), .wr_addr(wr_addr), .wr_data(wr_data)
    );
endmodule

// File: rtl/rrs_chk.sv
// Protocol checks on the sequencer, bound into the top module.
module rrs_chk #(
    parameter logic [7:0] LO = 8'h80,
    parameter logic [7:0] HI = 8'hCF
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_byte,
    input logic       ev_mack,
    input logic       mack_ack,
    input logic       ev_stop,
    input logic       wel,
    input logic       wp_n,
    input logic       ack_valid,
    input logic       tx_load,
    input logic [7:0] tx_byte,
    input logic [7:0] rd_ptr,
    input logic       wr_go
);
    // R2
    ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ev_byte));

    // R5
    load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> ($past(ev_byte) || $past(ev_mack && mack_ack)));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> rd_ptr == $past(rd_ptr) + 8'd1);

    // R6
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && ($past(rd_ptr) < LO || $past(rd_ptr) > HI)) |-> tx_byte == 8'hFF);

    // R8
    protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (wel && wp_n && ev_stop));
endmodule

bind rand_read_seq rrs_chk #(.LO(LO), .HI(HI)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_byte(ev_byte), .ev_mack(ev_mack),
    .mack_ack(mack_ack), .ev_stop(ev_stop), .wel(wel), .wp_n(wp_n),
    .ack_valid(ack_valid), .tx_load(tx_load), .tx_byte(tx_byte),
    .rd_ptr(rd_ptr), .wr_go(wr_go)
);

// File: tb/sim_rand_read_seq.sv
module sim_rand_read_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start = 0, ev_stop = 0, ev_bit = 0, ev_byte = 0, ev_mack = 0, mack_ack = 0;
    logic [7:0] rx_byte = 8'h00;
    logic wel = 1'b1, wp_n = 1'b1;
    logic ack_valid, ack_out, tx_load;
    logic [7:0] tx_byte, rd_ptr;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [80];
    logic av, ao, tl;
    logic [7:0] tb;

    always #10 clk = ~clk;

    rand_read_seq u0 (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_bit(ev_bit), .ev_byte(ev_byte), .rx_byte(rx_byte),
        .ev_mack(ev_mack), .mack_ack(mack_ack), .wel(wel), .wp_n(wp_n),
        .ack_valid(ack_valid), .ack_out(ack_out), .tx_load(tx_load),
        .tx_byte(tx_byte), .rd_ptr(rd_ptr)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a >= 8'h80 && a <= 8'hCF) return model[a - 8'h80];
        return 8'hFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) ev_start = 1;
        @(negedge clk) ev_start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) ev_stop = 1;
        @(negedge clk) ev_stop = 0;
    endtask

    task automatic bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ev_bit = 1;
        end
        @(negedge clk) ev_bit = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int n);
        bits(n);
        ev_byte = 1; rx_byte = b;
        @(negedge clk) ev_byte = 0;
        av = ack_valid; ao = ack_out; tl = tx_load; tb = tx_byte;
    endtask

    task automatic send_mack(input logic a);
        bits(8);
        ev_mack = 1; mack_ack = a;
        @(negedge clk) ev_mack = 0;
        tl = tx_load; tb = tx_byte;
    endtask

    task automatic do_write(input logic [7:0] addr, input logic [7:0] d,
                            input logic we, input logic wpn);
        wel = we; wp_n = wpn;
        pulse_start();
        send_byte(8'hA0, 8); chk("R2 write dev ack", {av, ao}, 2'b11);
        send_byte(addr, 8);  chk("R3 addr ack", {av, ao}, 2'b11);
        chk("R3 pointer", rd_ptr, addr);
        send_byte(d, 8);     chk("R7 data ack", {av, ao}, 2'b11);
        pulse_stop();
        if (we && wpn && addr >= 8'h80 && addr <= 8'hCF) model[addr - 8'h80] = d;
        wel = 1; wp_n = 1;
    endtask

    task automatic do_read(input logic [7:0] addr, input int n);
        pulse_start();
        send_byte(8'hA0, 8);
        send_byte(addr, 8);
        pulse_start();
        send_byte(8'hA1, 8);
        chk("R4 read dev ack", {av, ao, tl}, 3'b111);
        chk("R4/R6 first byte", tb, exp_rd(addr));
        chk("R4 pointer step", rd_ptr, 8'(addr + 8'd1));
        for (int k = 1; k < n; k++) begin
            send_mack(1'b1);
            chk("R5 next load", tl, 1'b1);
            chk("R5/R6 next byte", tb, exp_rd(8'(addr + k)));
        end
        send_mack(1'b0);
        chk("R5 nack no load", tl, 1'b0);
        pulse_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 80; i++) model[i] = 8'h00;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ack_valid", ack_valid, 1'b0);
        chk("R1 tx_load", tx_load, 1'b0);
        chk("R1 rd_ptr", rd_ptr, 8'h80);
        do_read(8'hA0, 2);

        // R2 mismatching device address
        pulse_start();
        send_byte(8'hB0, 8); chk("R2 mismatch nack", {av, ao}, 2'b10);
        send_byte(8'h85, 8); chk("R2 ignored after mismatch", av, 1'b0);
        pulse_stop();

        // R3 pointer load
        pulse_start();
        send_byte(8'hA0, 8); send_byte(8'h9C, 8);
        chk("R3 rd_ptr", rd_ptr, 8'h9C);
        pulse_stop();

        // R7 basic write and readback
        do_write(8'h90, 8'h3C, 1, 1);
        do_read(8'h90, 1);

        // R8 protection
        do_write(8'h90, 8'hAA, 0, 1);
        do_write(8'h90, 8'h55, 1, 0);
        do_read(8'h90, 1);

        // R9 stop mid-byte
        pulse_start();
        send_byte(8'hA0, 8); send_byte(8'h91, 8); send_byte(8'h77, 8);
        bits(3);
        pulse_stop();
        do_read(8'h91, 1);

        // R10 short byte
        pulse_start();
        send_byte(8'hA0, 7); chk("R10 short byte nack", {av, ao}, 2'b10);
        send_byte(8'hA0, 8); chk("R10 ignored until start", av, 1'b0);
        pulse_stop();

        // R11 second data byte
        pulse_start();
        send_byte(8'hA0, 8); send_byte(8'h92, 8); send_byte(8'h11, 8);
        send_byte(8'h22, 8); chk("R11 extra byte nack", {av, ao}, 2'b10);
        pulse_stop();
        do_read(8'h92, 1);

        // R5 no load after nack
        pulse_start();
        send_byte(8'hA1, 8);
        send_mack(1'b0);
        send_mack(1'b1); chk("R5 held after nack", tl, 1'b0);
        pulse_stop();

        // R6 window edges
        do_write(8'hCF, 8'h5D, 1, 1);
        do_write(8'h80, 8'hE1, 1, 1);
        do_read(8'h7E, 4);
        do_read(8'hCE, 4);
        do_write(8'hD4, 8'h66, 1, 1);
        do_read(8'hD4, 2);

        // R12 stop and start together
        pulse_start();
        send_byte(8'hA0, 8); send_byte(8'hB3, 8); send_byte(8'h4E, 8);
        @(negedge clk) begin ev_stop = 1; ev_start = 1; end
        @(negedge clk) begin ev_stop = 0; ev_start = 0; end
        model[8'hB3 - 8'h80] = 8'h4E;
        send_byte(8'hA1, 8);
        chk("R12 dev ack after combined", {av, ao, tl}, 3'b111);
        chk("R12 committed byte", tb, 8'h4E);
        send_mack(1'b0);
        pulse_stop();

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [7:0] a;
            a = 8'h7C + 8'($urandom % 88);
            if ($urandom % 2)
                do_write(a, 8'($urandom), 1'($urandom % 4 != 0), 1'($urandom % 4 != 0));
            else
                do_read(a, 1 + int'($urandom % 5));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule